// File: doc/BRIEF.md
# Compressed Bounds Encoder

This block converts a requested memory region, given as a 64-bit start address and a 64-bit byte length, into a floating-point style bounds encoding. The encoding has a 6-bit exponent and two 20-bit mantissas. The bottom mantissa holds the start address with its low bits truncated. The top mantissa holds the end address (start plus length) rounded up to the next exponent step.

Before the exponent is chosen, the length is inflated by one sixty-fourth. This keeps at least a page of slack representable on both sides of the region. The exponent is then rounded up to a multiple of four. A flag reports whether the region is encoded without rounding. When the request is for a sealed encoding, a second flag reports a fault if either mantissa has nonzero bits in its twelve low positions.

All results are registered, so they appear one clock after the request is presented.

Top module: `bounds_enc`

## Requirements
- R1: All outputs come from registers and reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low, every output is zero.
- R2: The raw exponent is the index of the highest set bit of `(len + (len >> 6)) >> 19`. The sum is formed in 65 bits so that no carry is lost. The raw exponent is 0 when that value is zero.
- R3: The output exponent `exp_o` is the raw exponent rounded up to a multiple of four (a raw value of 1 gives 4). It is limited to 60.
- R4: `bot_o` equals bits [19+E:E] of the start address, where E is `exp_o`.
- R5: `top_o` equals bits [19+E:E] of the 65-bit sum start + length, plus one when any bit of that sum below position E is set. The result is taken modulo 2^20.
- R6: `exact_o` is 1 only when the start address and the 65-bit end address both have all bits below position E clear.
- R7: `seal_fault_o` is 1 when `seal_req` was set and either `bot_o[11:0]` or `top_o[11:0]` is nonzero. It is never set for a request without `seal_req`.
- R8: The chosen E is the smallest multiple of four for which the inflated length is below 2^(E+20). For that E, both `len + 8192 <= 2^(E+20)` and the rounded region fits in 2^(E+20) bytes.
- R9: A zero-length request gives E = 0, `bot_o == top_o` and `exact_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_base | input | 64 | Requested region start address |
| req_len | input | 64 | Requested region length in bytes |
| seal_req | input | 1 | Request targets the sealed encoding |
| exp_o | output | 6 | Encoded exponent |
| bot_o | output | 20 | Bottom mantissa |
| top_o | output | 20 | Top mantissa |
| exact_o | output | 1 | Encoding is exact (no rounding) |
| seal_fault_o | output | 1 | Sealed encoding would lose low mantissa bits |

## Verification
Every result is due exactly one rising edge after its request. The bench changes inputs on the falling edge and reads the outputs on the following falling edge, so exactly one capturing edge lies between stimulus and sample.

A dedicated latency check reads the outputs once more just before that edge, to confirm they still hold the previous result. The bound properties compare each output with the inputs one edge earlier. They are enabled only from the second edge after reset, so the reset values are never judged against a request.

// File: rtl/bounds_enc.sv
module bounds_enc #(
  parameter int ADDR_W   = 64,
  parameter int MANT_W   = 20,
  parameter int EXP_W    = 6,
  parameter int INFL_SH  = 6,
  parameter int EXP_GRAN = 4,
  parameter int SEAL_LSB = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [ADDR_W-1:0] req_len,
  input  logic              seal_req,
  output logic [EXP_W-1:0]  exp_o,
  output logic [MANT_W-1:0] bot_o,
  output logic [MANT_W-1:0] top_o,
  output logic              exact_o,
  output logic              seal_fault_o
);
  localparam int SUM_W   = ADDR_W + 1;
  localparam int SH_W    = SUM_W - (MANT_W - 1);
  localparam int WIDE_W  = EXP_W + 2;
  localparam int EXP_MAX = ((1 << EXP_W) - 1) & ~(EXP_GRAN - 1);

  logic [SUM_W-1:0]  inflated;
  logic [SH_W-1:0]   shifted;
  logic [WIDE_W-1:0] raw_e;
  logic [WIDE_W-1:0] rnd_e;
  logic [EXP_W-1:0]  e_sel;
  logic [ADDR_W-1:0] low_mask;
  logic [SUM_W-1:0]  top_sum;
  logic              base_lo_nz;
  logic              top_lo_nz;
  logic [MANT_W-1:0] b_mant;
  logic [MANT_W-1:0] t_mant;
  logic              fault;

  assign inflated = {1'b0, req_len} + {1'b0, req_len >> INFL_SH};
  assign shifted  = SH_W'(inflated >> (MANT_W - 1));

  always_comb begin
    raw_e = '0;
    for (int i = 0; i < SH_W; i++)
      if (shifted[i]) raw_e = WIDE_W'(i);
  end

  assign rnd_e = (raw_e + WIDE_W'(EXP_GRAN - 1)) & ~WIDE_W'(EXP_GRAN - 1);
  assign e_sel = (rnd_e > WIDE_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : rnd_e[EXP_W-1:0];

  assign low_mask   = ~({ADDR_W{1'b1}} << e_sel);
  assign top_sum    = {1'b0, req_base} + {1'b0, req_len};
  assign base_lo_nz = |(req_base & low_mask);
  assign top_lo_nz  = |(top_sum[ADDR_W-1:0] & low_mask);

  assign b_mant = MANT_W'(req_base >> e_sel);
  assign t_mant = MANT_W'(top_sum >> e_sel) + {{(MANT_W-1){1'b0}}, top_lo_nz};
  assign fault  = seal_req & ((|b_mant[SEAL_LSB-1:0]) | (|t_mant[SEAL_LSB-1:0]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_o        <= '0;
      bot_o        <= '0;
      top_o        <= '0;
      exact_o      <= 1'b0;
      seal_fault_o <= 1'b0;
    end else begin
      exp_o        <= e_sel;
      bot_o        <= b_mant;
      top_o        <= t_mant;
      exact_o      <= ~base_lo_nz & ~top_lo_nz;
      seal_fault_o <= fault;
    end
  end
endmodule

// File: rtl/bounds_enc_chk.sv
module bounds_enc_chk #(
  parameter int ADDR_W = 64,
  parameter int MANT_W = 20,
  parameter int EXP_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] req_len,
  input logic              seal_req,
  input logic [EXP_W-1:0]  exp_o,
  input logic [MANT_W-1:0] bot_o,
  input logic [MANT_W-1:0] top_o,
  input logic              exact_o,
  input logic              seal_fault_o
);
  localparam int EXP_MAX = ((1 << EXP_W) - 1) & ~3;

  logic primed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;

  p_exp_gran_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exp_o[1:0] == 2'b00);

  p_exp_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exp_o <= EXP_W'(EXP_MAX));

  p_fault_needs_seal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seal_fault_o |-> $past(seal_req));

  p_no_fault_unsealed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !$past(seal_req)) |-> !seal_fault_o);

  p_zero_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(req_len) == '0) |-> (exp_o == '0 && bot_o == top_o && exact_o));

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |-> (exp_o == '0 && bot_o == '0 && top_o == '0 && !exact_o && !seal_fault_o));
endmodule

bind bounds_enc bounds_enc_chk #(.ADDR_W(ADDR_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_len(req_len), .seal_req(seal_req),
  .exp_o(exp_o), .bot_o(bot_o), .top_o(top_o), .exact_o(exact_o),
  .seal_fault_o(seal_fault_o)
);

// File: tb/bounds_enc_tb.sv
`timescale 1ns/1ps
module bounds_enc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] req_base = '0;
  logic [63:0] req_len = '0;
  logic        seal_req = 1'b0;
  logic [5:0]  exp_o;
  logic [19:0] bot_o, top_o;
  logic        exact_o, seal_fault_o;
  int          n_checks = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;

  bounds_enc u_dut (
    .clk(clk), .rst_n(rst_n), .req_base(req_base), .req_len(req_len),
    .seal_req(seal_req), .exp_o(exp_o), .bot_o(bot_o), .top_o(top_o),
    .exact_o(exact_o), .seal_fault_o(seal_fault_o)
  );

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp_v);
    n_checks++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic apply_check(input logic [63:0] base, input logic [63:0] len,
                             input logic seal, input string tag);
    logic [71:0] infl, top, one, ceil_top, span;
    int e;
    logic [19:0] eb, et;
    logic ex, sf;
    infl = {8'b0, len} + ({8'b0, len} >> 6);
    e = 0;
    while (e < 60 && infl >= (72'd1 << (e + 20))) e += 4;
    one = 72'd1 << e;
    top = {8'b0, base} + {8'b0, len};
    eb = 20'(({8'b0, base}) >> e);
    ceil_top = (top + one - 72'd1) >> e;
    et = ceil_top[19:0];
    ex = ((({8'b0, base}) & (one - 72'd1)) == 0) && ((top & (one - 72'd1)) == 0);
    sf = seal && ((eb[11:0] != 0) || (et[11:0] != 0));
    span = (ceil_top << e) - ((({8'b0, base}) >> e) << e);
    req_base = base; req_len = len; seal_req = seal;
    @(negedge clk);
    chk({"R2 R3 exponent ", tag}, 72'(exp_o), 72'(e));
    chk({"R4 bottom ", tag}, 72'(bot_o), 72'(eb));
    chk({"R5 top ", tag}, 72'(top_o), 72'(et));
    chk({"R6 exact ", tag}, 72'(exact_o), 72'(ex));
    chk({"R7 seal fault ", tag}, 72'(seal_fault_o), 72'(sf));
    chk({"R8 slack ", tag}, 72'(({8'b0, len} + 72'd8192) <= (72'd1 << (e + 20))), 72'd1);
    chk({"R8 span fits ", tag}, 72'(span <= (72'd1 << (e + 20))), 72'd1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    req_base = 64'h1234_5678_9abc_def1; req_len = 64'hffff_ffff; seal_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs zero", {exp_o, bot_o, top_o, exact_o, seal_fault_o}, '0);
    rst_n = 1'b1;
  endtask

  task automatic t_latency;
    apply_check(64'h1000, 64'h40, 1'b0, "latency first");
    req_base = 64'h0000_0000_0100_0003; req_len = 64'h0400_0000; seal_req = 1'b0;
    #2;
    chk("R1 output held before edge", 72'(exp_o), 72'd0);
    @(negedge clk);
    chk("R1 output updated after edge", 72'(exp_o), 72'd8);
  endtask

  task automatic t_zero_len;
    apply_check(64'hdead_beef_0000_0007, 64'd0, 1'b0, "R9 zero length");
    chk("R9 bottom equals top", 72'(bot_o == top_o), 72'd1);
    chk("R9 exact", 72'(exact_o), 72'd1);
  endtask

  task automatic t_thresholds;
    apply_check(64'h0, 64'd1032444, 1'b0, "below first step");
    chk("R3 exponent stays zero", 72'(exp_o), 72'd0);
    apply_check(64'h0, 64'd1032445, 1'b0, "first step");
    chk("R3 raw 0->1 rounds to 4", 72'(exp_o), 72'd4);
    apply_check(64'h30, 64'h0200_0000, 1'b0, "mid range");
    apply_check(64'h0, 64'hffff_ffff_ffff_ffff, 1'b0, "full length");
    chk("R2 65-bit sum exponent", 72'(exp_o), 72'd48);
    apply_check(64'hffff_ffff_ffff_f000, 64'h2000, 1'b0, "end above 2^64");
  endtask

  task automatic t_rounding;
    apply_check(64'h0000_0010_0000_0011, 64'h0123_4567, 1'b0, "inexact both");
    apply_check(64'h0000_0010_0000_0000, 64'h0100_0000, 1'b0, "aligned exact");
    apply_check(64'h0000_0000_0000_0100, 64'h00ff_fff1, 1'b0, "top rounds up");
    apply_check(64'h0000_0000_00ff_fff0, 64'h0000_0010, 1'b0, "top mantissa wraps");
  endtask

  task automatic t_seal;
    apply_check(64'h0000_0000_1000_0000, 64'h1000_0000, 1'b1, "sealed aligned");
    chk("R7 aligned seal no fault", 72'(seal_fault_o), 72'd0);
    apply_check(64'h0000_0000_0000_1234, 64'h100, 1'b1, "sealed misaligned");
    chk("R7 misaligned seal faults", 72'(seal_fault_o), 72'd1);
    apply_check(64'h0000_0000_0000_1234, 64'h100, 1'b0, "unsealed misaligned");
    chk("R7 no fault without seal", 72'(seal_fault_o), 72'd0);
  endtask

  task automatic t_random;
    for (int k = 0; k < 400; k++) begin
      logic [63:0] b, l;
      b = {$urandom, $urandom};
      l = {$urandom, $urandom} >> ($urandom % 64);
      if (k % 3 == 0) b = b >> ($urandom % 64);
      apply_check(b, l, 1'($urandom % 2), "random");
    end
  endtask

  initial begin
    #(8 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_latency();
    t_zero_len();
    t_thresholds();
    t_rounding();
    t_seal();
    t_random();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule